// File: doc/BRIEF.md
# Convolutional Byte Interleaver

This block spreads a byte stream over time with a cyclic bank of delay branches, so that a burst of corrupted bytes on the channel lands in many different code words after the inverse operation. Each accepted byte is routed to the next branch in a fixed rotation. The branch delay grows in steps of a fixed unit, so branch 0 passes the byte straight through and the last branch holds it longest. The same hardware acts as the inverse operation when its direction input is set. The rotation then runs backwards, so the branch with the longest delay on one side pairs with the branch with no delay on the other.

The delay branches are not built as shift registers. Every branch owns a window of single-port RAM and a cyclic pointer. In the cycle a byte arrives, the location under the pointer is read to produce the output, and the new byte is written back to the same location one cycle later. The window bounds of the branch in use are computed from its index with a multiply and an add. The windows are split over two RAM banks by branch parity. The deferred write of one byte then always falls in a different bank from the read of the next byte.

A packet-start flag on the input re-aligns the rotation. A system places one instance in the transmit path and a second one, set to the inverse direction, in the receive path. It feeds the receive instance with the packet-start flag wherever a packet start leaves the transmit instance.

Top module: `conv_byte_ilv`

## Requirements
- R1: After reset `out_valid` is low, and it stays low until a byte is accepted.
- R2: A byte routed to branch 0 appears on `out_byte` in the cycle after it is accepted, unchanged.
- R3: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise. Each accepted byte yields exactly one output byte.
- R4: A byte accepted on branch b (1 ≤ b ≤ NB-1) leaves the block after NB·M·b further accepted bytes. Its output slot is the one produced when the byte accepted NB·M·b positions later is taken in.
- R5: With `mode_deint` = 0 the branch index rises by one for each accepted byte and wraps from NB-1 to 0. An accepted byte with `in_sync` high is placed on branch 0.
- R6: With `mode_deint` = 1 the branch index falls by one for each accepted byte and wraps from 0 to NB-1. An accepted byte with `in_sync` high is placed on branch NB-1.
- R7: With `mode_deint` = 1, `in_sync` is ignored for a byte accepted in the cycle right after a byte on an odd branch. That byte keeps the counted branch.
- R8: An interleaver followed by an inverse instance returns the input stream after exactly M·NB·(NB-1) accepted bytes. A packet start (every 204th byte) lands on a packet-start position again.
- R9: No RAM bank is read and written in the same cycle.
- R10: Cycles with `in_valid` low advance neither the branch index nor any branch pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_deint | input | 1 | 0: interleave, 1: inverse (deinterleave) |
| in_byte | input | DW | Input byte |
| in_valid | input | 1 | Input byte is present this cycle |
| in_sync | input | 1 | Input byte is a packet start |
| out_byte | output | DW | Output byte |
| out_valid | output | 1 | Output byte is present this cycle |

## Verification
Random gaps in the input valid test that idle cycles freeze the rotation and the pointers. A design that advanced on idle cycles would put bytes on the wrong branch, and the per-branch delay checks would fail. The bench injects a packet start in the middle of a packet, which tests re-alignment to branch 0. It also sends a burst of back-to-back packet starts to the inverse instance, so that both the honoured case and the ignored case of the bank-collision rule occur. A design that always honoured the flag would corrupt the deferred write or take the wrong branch. The chained run compares the stream after the full end-to-end delay. An off-by-one branch window or pointer wrap shifts bytes by whole rotations and breaks that equality.

// File: rtl/cbi_pkg.sv
package cbi_pkg;

  typedef enum logic {
    DIR_ILV = 1'b0,
    DIR_DIL = 1'b1
  } dir_e;

  // First RAM word of branch b inside its parity bank (branch unit length m).
  function automatic int unsigned seg_base(input int unsigned b, input int unsigned m);
    int unsigned j;
    j = b >> 1;
    if ((b % 2) == 1) return m * j * j;
    else if (j == 0) return 0;
    else return m * j * (j - 1);
  endfunction

  // Words needed by the bank holding branches of parity par.
  function automatic int unsigned bank_depth(input int unsigned nb, input int unsigned m,
                                             input int unsigned par);
    int unsigned last;
    last = (((nb - 1) % 2) == par) ? nb - 1 : nb - 2;
    return seg_base(last, m) + m * last;
  endfunction

endpackage

// File: rtl/cbi_spram.sv
module cbi_spram #(
  parameter int DW    = 8,
  parameter int DEPTH = 612,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // One access per cycle: a write or a registered read.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/cbi_branch_seq.sv
module cbi_branch_seq import cbi_pkg::*; #(
  parameter int NB = 12,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir,
  input  logic          acc,
  input  logic          sync,
  input  logic          hold_sync,
  output logic [BW-1:0] cur_b
);

  logic [BW-1:0] cnt_q, cnt_d;

  always_comb begin
    cur_b = cnt_q;
    if (sync) begin
      if (dir == DIR_ILV)  cur_b = '0;
      else if (!hold_sync) cur_b = BW'(NB - 1);
    end
    cnt_d = cnt_q;
    if (acc) begin
      if (dir == DIR_DIL) cnt_d = (cur_b == '0) ? BW'(NB - 1) : cur_b - BW'(1);
      else                cnt_d = (cur_b == BW'(NB - 1)) ? '0 : cur_b + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (acc) cnt_q <= cnt_d;
  end

  // R5: interleave sync restarts the rotation at branch 0, so branch 1 follows
  a_r5_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sync && dir == DIR_ILV) |=> (cnt_q == BW'(1)));

  // R6: an honoured inverse-mode sync lands on the last branch
  a_r6_dil_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sync && dir == DIR_DIL && !hold_sync) |=> (cnt_q == BW'(NB - 2)));

  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < BW'(NB));

  // R10: idle cycles leave the rotation untouched
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(cnt_q));

endmodule

// File: rtl/cbi_ptr_file.sv
module cbi_ptr_file import cbi_pkg::*; #(
  parameter int NB = 12,
  parameter int M  = 17,
  parameter int BW = 4,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [BW-1:0] cur_b,
  output logic [AW-1:0] cur_ptr
);

  logic [AW-1:0] ptr_q [NB];
  logic [AW-1:0] lo, hi, nxt;

  // Window bounds of the selected branch, computed from its index.
  always_comb begin
    lo      = AW'(seg_base(32'(cur_b), M));
    hi      = lo + AW'(M * 32'(cur_b) - 1);
    cur_ptr = ptr_q[cur_b];
    nxt     = (cur_ptr == hi) ? lo : cur_ptr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) ptr_q[b] <= AW'(seg_base(b, M));
    end else if (adv) begin
      ptr_q[cur_b] <= nxt;
    end
  end

  for (genvar g = 1; g < NB; g++) begin : g_win
    localparam int LO = int'(seg_base(g, M));
    localparam int HI = LO + M * g - 1;
    // R4: each branch pointer stays inside its own window
    a_r4_ptr_window: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ptr_q[g]) >= LO) && (int'(ptr_q[g]) <= HI));
    // R10: a pointer only moves when its branch takes a byte
    a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr_q[g]));
  end

endmodule

// File: rtl/conv_byte_ilv.sv
module conv_byte_ilv import cbi_pkg::*; #(
  parameter int DW = 8,
  parameter int NB = 12,
  parameter int M  = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_deint,
  input  logic [DW-1:0] in_byte,
  input  logic          in_valid,
  input  logic          in_sync,
  output logic [DW-1:0] out_byte,
  output logic          out_valid
);

  localparam int   BW        = $clog2(NB);
  localparam int   D0        = int'(bank_depth(NB, M, 0));
  localparam int   D1        = int'(bank_depth(NB, M, 1));
  localparam int   DMAX      = (D0 > D1) ? D0 : D1;
  localparam int   AW        = $clog2(DMAX);
  localparam logic LAST_BANK = ((NB - 1) % 2) == 1;

  logic [BW-1:0] cur_b;
  logic [AW-1:0] cur_ptr;
  logic          mem_use, cur_bank, hold_sync;

  logic          pend_we_q, pend_we_d;
  logic          pend_bank_q, pend_bank_d;
  logic [AW-1:0] pend_addr_q, pend_addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          vld_q, vld_d;
  logic          sel_ram_q, sel_ram_d;
  logic [DW-1:0] bank_rd [2];

  assign mem_use   = in_valid && (cur_b != '0);
  assign cur_bank  = cur_b[0];
  assign hold_sync = pend_we_q && (pend_bank_q == LAST_BANK);

  cbi_branch_seq #(.NB(NB), .BW(BW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir       (mode_deint),
    .acc       (in_valid),
    .sync      (in_sync),
    .hold_sync (hold_sync),
    .cur_b     (cur_b)
  );

  cbi_ptr_file #(.NB(NB), .M(M), .BW(BW), .AW(AW)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (mem_use),
    .cur_b   (cur_b),
    .cur_ptr (cur_ptr)
  );

  // Next state of the one-cycle stage: deferred write and output select.
  always_comb begin
    pend_we_d   = mem_use;
    vld_d       = in_valid;
    sel_ram_d   = mem_use;
    pend_bank_d = pend_bank_q;
    pend_addr_d = pend_addr_q;
    data_d      = data_q;
    if (in_valid) begin
      pend_bank_d = cur_bank;
      pend_addr_d = cur_ptr;
      data_d      = in_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_we_q   <= 1'b0;
      vld_q       <= 1'b0;
      sel_ram_q   <= 1'b0;
      pend_bank_q <= 1'b0;
      pend_addr_q <= '0;
      data_q      <= '0;
    end else begin
      pend_we_q <= pend_we_d;
      vld_q     <= vld_d;
      sel_ram_q <= sel_ram_d;
      if (in_valid) begin
        pend_bank_q <= pend_bank_d;
        pend_addr_q <= pend_addr_d;
        data_q      <= data_d;
      end
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_bank
    logic          rd_en, wr_en;
    logic [AW-1:0] addr;
    logic [DW-1:0] rdata;

    assign rd_en = mem_use && (cur_bank == 1'(k));
    assign wr_en = pend_we_q && (pend_bank_q == 1'(k));
    assign addr  = wr_en ? pend_addr_q : cur_ptr;

    cbi_spram #(.DW(DW), .DEPTH((k == 0) ? D0 : D1), .AW(AW)) u_ram (
      .clk   (clk),
      .en    (rd_en || wr_en),
      .we    (wr_en),
      .addr  (addr),
      .wdata (data_q),
      .rdata (rdata)
    );

    assign bank_rd[k] = rdata;

    // R9: a bank never sees a read and a write in one cycle
    a_r9_single_port: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en));
  end

  assign out_valid = vld_q;
  assign out_byte  = sel_ram_q ? bank_rd[pend_bank_q] : data_q;

  // R3: one output per accepted byte, one cycle later
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r3_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2: an interleave sync byte goes through branch 0 without delay
  a_r2_sync_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sync && !mode_deint) |=> (out_byte == $past(in_byte)));

endmodule

// File: tb/conv_byte_ilv_tb_top.sv
`timescale 1ns/1ps
module conv_byte_ilv_tb_top;

  localparam int NB   = 12;
  localparam int M    = 17;
  localparam int PKT  = 204;
  localparam int E2E  = M * NB * (NB - 1);
  localparam int NA   = PKT * 16;
  localparam int HCAP = 1024;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] i_byte;
  logic       i_valid, i_sync;
  logic [7:0] m_byte, o_byte;
  logic       m_valid, o_valid, d_sync;
  logic       extra_d;

  int checks = 0;
  int errors = 0;
  int m_cnt  = 0;
  int o_cnt  = 0;
  int i_cnt  = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  int hist [2][NB][HCAP];
  int wcnt [2][NB];
  int mcnt [2];
  bit prev_odd [2];
  int in_seq [8192];

  bit iv_e = 1'b0, ov_e = 1'b0;
  int ib_e = -1, ob_e = -1, itag = 0, otag = 0;

  always #2.5 clk = ~clk;

  conv_byte_ilv #(.DW(8), .NB(NB), .M(M)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_deint(1'b0),
    .in_byte(i_byte), .in_valid(i_valid), .in_sync(i_sync),
    .out_byte(m_byte), .out_valid(m_valid)
  );

  conv_byte_ilv #(.DW(8), .NB(NB), .M(M)) deint_i (
    .clk(clk), .rst_n(rst_n), .mode_deint(1'b1),
    .in_byte(m_byte), .in_valid(m_valid), .in_sync(d_sync),
    .out_byte(o_byte), .out_valid(o_valid)
  );

  // Packet starts leave the interleaver at every 204th output byte.
  assign d_sync = m_valid && (((m_cnt % PKT) == 0) || extra_d);

  always @(posedge clk) if (m_valid) m_cnt <= m_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tag_name(input int t);
    case (t)
      2:       return "R2";
      5:       return "R5";
      6:       return "R6";
      7:       return "R7";
      default: return "R4/R10";
    endcase
  endfunction

  // Reference model built from R2, R4..R7: per-branch history of written bytes.
  task automatic model_step(input int u, input bit dil, input bit v, input bit s,
                            input int din, output bit ev, output int eb, output int tag);
    int b, idx;
    ev = v; eb = -1; tag = 4;
    if (!v) begin
      prev_odd[u] = 1'b0;
      return;
    end
    b = mcnt[u];
    if (dil) tag = 6;
    if (s && !dil) begin
      b = 0; tag = 5;
    end else if (s && dil) begin
      if (prev_odd[u]) tag = 7;
      else begin b = NB - 1; tag = 6; end
    end
    if (b == 0) begin
      eb = din;
      if (tag == 4) tag = 2;
    end else begin
      idx = wcnt[u][b];
      if (idx >= M * b) eb = hist[u][b][idx - M * b];
      hist[u][b][idx] = din;
      wcnt[u][b] = idx + 1;
    end
    prev_odd[u] = (b % 2) == 1;
    if (dil) mcnt[u] = (b == 0) ? NB - 1 : b - 1;
    else     mcnt[u] = (b == NB - 1) ? 0 : b + 1;
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on && !done) begin
      chk(m_valid == iv_e, "R3", int'(m_valid), int'(iv_e));
      if (iv_e && ib_e >= 0) chk(int'(m_byte) == ib_e, tag_name(itag), int'(m_byte), ib_e);
      chk(o_valid == ov_e, "R3", int'(o_valid), int'(ov_e));
      if (ov_e && ob_e >= 0) chk(int'(o_byte) == ob_e, tag_name(otag), int'(o_byte), ob_e);
      if (o_valid) begin
        // R8: chained output equals input shifted by the end-to-end delay
        if (o_cnt >= E2E && o_cnt < NA)
          chk(int'(o_byte) == in_seq[o_cnt - E2E], "R8/R9", int'(o_byte), in_seq[o_cnt - E2E]);
        o_cnt++;
      end
      model_step(0, 1'b0, i_valid, i_sync, int'(i_byte), iv_e, ib_e, itag);
      if (i_valid) begin
        in_seq[i_cnt] = int'(i_byte);
        i_cnt++;
      end
      model_step(1, 1'b1, m_valid, d_sync, int'(m_byte), ov_e, ob_e, otag);
    end
  end

  task automatic send(input logic [7:0] b, input bit s, input bit gaps);
    @(posedge clk); #1;
    while (gaps && ($urandom_range(3) == 0)) begin
      i_valid = 1'b0; i_sync = 1'b0;
      @(posedge clk); #1;
    end
    i_valid = 1'b1; i_sync = s; i_byte = b;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      i_valid = 1'b0; i_sync = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0c1b));
    for (int u = 0; u < 2; u++) begin
      mcnt[u] = 0;
      prev_odd[u] = 1'b0;
      for (int b = 0; b < NB; b++) wcnt[u][b] = 0;
    end
    rst_n = 1'b0; i_valid = 1'b0; i_sync = 1'b0; i_byte = '0; extra_d = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: both instances idle after reset
    chk(!m_valid, "R1", int'(m_valid), 0);
    chk(!o_valid, "R1", int'(o_valid), 0);
    mon_on = 1'b1;

    // Aligned packets with random gaps: R2..R6, R8, R10
    for (int n = 0; n < NA; n++) begin
      if ((n % PKT) == 0) send(8'h47, 1'b1, 1'b1);
      else                send(8'($urandom_range(255)), 1'b0, 1'b1);
    end

    // Packet start in mid-packet re-aligns the interleaver to branch 0 (R5)
    for (int n = 0; n < 50; n++) send(8'($urandom_range(255)), 1'b0, 1'b1);
    send(8'hb8, 1'b1, 1'b1);
    for (int n = 0; n < 30; n++) send(8'($urandom_range(255)), 1'b0, 1'b1);

    // Back-to-back inverse-side packet starts: honoured and ignored cases (R6, R7)
    extra_d = 1'b1;
    for (int n = 0; n < 6; n++) send(8'($urandom_range(255)), 1'b0, 1'b0);
    @(posedge clk); #1;
    extra_d = 1'b0;
    i_valid = 1'b0; i_sync = 1'b0;
    for (int n = 0; n < 300; n++) send(8'($urandom_range(255)), 1'b0, 1'b1);
    idle(8);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule